// File: doc/BRIEF.md
# Single-Cycle 64-bit Load/Store Core

This block is a small processor that completes one instruction per clock. It holds thirty-two 64-bit general registers, one of which always reads as zero, and a 256-byte data memory organised as big-endian 8-byte double words. The instruction set has nine operations: register add and subtract, add and subtract with a zero-extended 12-bit immediate, a double-word load and a double-word store addressed by a base register plus a signed 9-bit offset, an unconditional relative jump, and jumps taken when a register is zero or non-zero. Jump offsets count instructions, so the program counter moves by four times the offset.

The core fetches over a plain combinational port. It presents a word index on `imem_addr` and expects the matching 32-bit instruction on `imem_data` in the same cycle. There is no streaming handshake at any edge of the block: every port is plain control, status or data sampled on the rising clock. The caller gives the program length in instructions. The core halts once the program counter reaches or passes four times that length.

A memory access that is not 8-byte aligned, or whose last byte falls past the end of memory, raises a sticky error, as does any unknown opcode. The failing instruction writes nothing and the program counter stays on it. Registers and memory have no reset value. While reset is held they are loaded through a preload port, and they are observed through combinational debug read ports.

Top module: `dwc_core`

## Requirements
- R1: Reset is synchronous. After reset the program counter is 0 and `err` is 0. `halted` is 0 whenever the program length is non-zero.
- R2: Register 31 always reads as zero. Any write to register 31 is discarded, whether it comes from execution or from the preload port.
- R3: Opcode 0x01 (add) and opcode 0x02 (subtract) use the R form: bits [31:26] opcode, [20:16] second source, [9:5] first source, [4:0] destination. The destination gets first+second or first−second, modulo 2^64, and the program counter advances by 4.
- R4: Opcode 0x03 (add immediate) and opcode 0x04 (subtract immediate) use the I form: imm12 in bits [21:10], source in [9:5], destination in [4:0]. The immediate is zero-extended to 64 bits before the add or subtract.
- R5: Opcode 0x05 (load) and opcode 0x06 (store) use the D form: signed imm9 in bits [20:12], base in [9:5], data register in [4:0]. The address is base plus the sign-extended offset. Memory byte A holds bits [63:56] of the double word at A, and byte A+7 holds bits [7:0].
- R6: A load or store whose address is not a multiple of 8 or is greater than 248 sets `err`. That instruction writes no register and no memory, and the program counter stays on it.
- R7: Any opcode other than 0x01 to 0x09 sets `err`, with no write and no change to the program counter.
- R8: Opcode 0x07 takes a signed imm26 in bits [25:0]. The program counter becomes PC + 4×imm, wrapped to the counter width.
- R9: Opcode 0x08 (jump if zero) and opcode 0x09 (jump if non-zero) take a signed imm19 in bits [23:5] and a test register in [4:0]. When taken, the program counter becomes PC + 4×imm. Otherwise it becomes PC + 4.
- R10: `halted` is high exactly when PC ≥ 4×`prog_len`. While it is high, nothing changes the program counter, the registers or the memory.
- R11: Once set, `err` stays high and the program counter stays frozen until reset.
- R12: The preload port writes register `pl_idx` or double word `pl_idx` (byte address 8×`pl_idx`) only while reset is high. Outside reset it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; enables preload |
| imem_addr | output | PC_W-2 | Instruction word index (PC/4) |
| imem_data | input | 32 | Instruction at `imem_addr`, same cycle |
| prog_len | input | PC_W-2 | Program length in instructions |
| pc | output | PC_W | Program counter, byte address |
| halted | output | 1 | Program counter has run past the program |
| err | output | 1 | Sticky fault flag |
| dbg_reg_sel | input | 5 | Register index for debug read |
| dbg_reg_val | output | 64 | Value of the selected register |
| dbg_mem_addr | input | MA_W | Byte address for debug read |
| dbg_mem_dword | output | 64 | Double word containing `dbg_mem_addr` |
| dbg_mem_byte | output | 8 | Byte at `dbg_mem_addr` |
| pl_reg_we | input | 1 | Preload register write (reset only) |
| pl_mem_we | input | 1 | Preload memory double-word write (reset only) |
| pl_idx | input | PL_W | Preload register or double-word index |
| pl_data | input | 64 | Preload data |

## Verification
A decode or ALU fault writes a wrong value into a register. That value appears on the debug read port as soon as the program stops, and usually spreads into later results first. A wrong next-PC shows on `imem_addr` in the very next cycle and changes which instructions run, so final register contents and the stop position both differ. A missed alignment or range check shows as a memory or register that changed when it should not have, or as `err` staying low with the program counter moving past the faulting instruction one edge later. Byte-lane order is checked directly through the byte debug output.

// File: rtl/dwc_pkg.sv
package dwc_pkg;
  localparam int XLEN   = 64;
  localparam int RIDX_W = 5;

  typedef enum logic [5:0] {
    OP_ADD  = 6'h01,
    OP_SUB  = 6'h02,
    OP_ADDI = 6'h03,
    OP_SUBI = 6'h04,
    OP_LDUR = 6'h05,
    OP_STUR = 6'h06,
    OP_B    = 6'h07,
    OP_CBZ  = 6'h08,
    OP_CBNZ = 6'h09
  } opcode_e;

  typedef enum logic [1:0] {PC_SEQ, PC_JUMP, PC_IFZ, PC_IFNZ} pc_sel_e;

  typedef struct packed {
    logic              illegal;
    logic              wr_reg;
    logic              use_imm;
    logic              do_sub;
    logic              mem_rd;
    logic              mem_wr;
    pc_sel_e           pc_sel;
    logic [RIDX_W-1:0] rd;
    logic [RIDX_W-1:0] rn;
    logic [RIDX_W-1:0] rb;
  } ctrl_t;
endpackage

// File: rtl/dwc_decode.sv
module dwc_decode
  import dwc_pkg::*;
(
  input  logic [31:0]     instr,
  output ctrl_t           ctrl,
  output logic [XLEN-1:0] imm
);
  logic [5:0] op;
  assign op = instr[31:26];

  always_comb begin
    ctrl        = '0;
    ctrl.pc_sel = PC_SEQ;
    ctrl.rd     = instr[4:0];
    ctrl.rn     = instr[9:5];
    ctrl.rb     = instr[4:0];
    imm         = '0;
    case (op)
      OP_ADD: begin
        ctrl.wr_reg = 1'b1;
        ctrl.rb     = instr[20:16];
      end
      OP_SUB: begin
        ctrl.wr_reg = 1'b1;
        ctrl.do_sub = 1'b1;
        ctrl.rb     = instr[20:16];
      end
      OP_ADDI: begin
        ctrl.wr_reg  = 1'b1;
        ctrl.use_imm = 1'b1;
        imm          = XLEN'(instr[21:10]);
      end
      OP_SUBI: begin
        ctrl.wr_reg  = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.do_sub  = 1'b1;
        imm          = XLEN'(instr[21:10]);
      end
      OP_LDUR: begin
        ctrl.wr_reg  = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.mem_rd  = 1'b1;
        imm          = {{(XLEN-9){instr[20]}}, instr[20:12]};
      end
      OP_STUR: begin
        ctrl.use_imm = 1'b1;
        ctrl.mem_wr  = 1'b1;
        imm          = {{(XLEN-9){instr[20]}}, instr[20:12]};
      end
      OP_B: begin
        ctrl.pc_sel = PC_JUMP;
        imm         = {{(XLEN-26){instr[25]}}, instr[25:0]};
      end
      OP_CBZ: begin
        ctrl.pc_sel = PC_IFZ;
        imm         = {{(XLEN-19){instr[23]}}, instr[23:5]};
      end
      OP_CBNZ: begin
        ctrl.pc_sel = PC_IFNZ;
        imm         = {{(XLEN-19){instr[23]}}, instr[23:5]};
      end
      default: ctrl.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/dwc_regfile.sv
module dwc_regfile
  import dwc_pkg::*;
#(
  parameter int NRD = 3
) (
  input  logic              clk,
  input  logic              we,
  input  logic [RIDX_W-1:0] widx,
  input  logic [XLEN-1:0]   wdata,
  input  logic [RIDX_W-1:0] rd_idx [NRD],
  output logic [XLEN-1:0]   rd_val [NRD]
);
  localparam int NREG = 2 ** RIDX_W;
  localparam logic [RIDX_W-1:0] ZR = RIDX_W'(NREG - 1);

  // Storage for every register except the hard-wired zero one
  logic [XLEN-1:0] bank [NREG-1];

  always_ff @(posedge clk) begin
    if (we && widx != ZR) bank[widx] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_val[p] = (rd_idx[p] == ZR) ? '0 : bank[rd_idx[p]];
  end
endmodule

// File: rtl/dwc_dmem.sv
module dwc_dmem
  import dwc_pkg::*;
#(
  parameter  int MEM_BYTES = 256,
  localparam int MA_W      = $clog2(MEM_BYTES),
  localparam int NDW       = MEM_BYTES / 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [MA_W-1:0] addr,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] rdata,
  input  logic [MA_W-1:0] dbg_addr,
  output logic [XLEN-1:0] dbg_dword,
  output logic [7:0]      dbg_byte
);
  logic [XLEN-1:0] dw [NDW];
  logic [7:0]      lane [8];

  always_ff @(posedge clk) begin
    if (we) dw[addr[MA_W-1:3]] <= wdata;
  end

  assign rdata     = dw[addr[MA_W-1:3]];
  assign dbg_dword = dw[dbg_addr[MA_W-1:3]];

  // Big-endian lanes: lowest byte address carries the top bits
  for (genvar k = 0; k < 8; k++) begin : g_lane
    assign lane[k] = dbg_dword[XLEN-1-8*k -: 8];
  end
  assign dbg_byte = lane[dbg_addr[2:0]];

  // R5/R6: the write port only ever sees aligned double-word addresses
  p_wr_aligned_r6: assert property (@(posedge clk) disable iff (rst)
    we |-> addr[2:0] == 3'b000);
endmodule

// File: rtl/dwc_core.sv
module dwc_core
  import dwc_pkg::*;
#(
  parameter  int MEM_BYTES = 256,
  parameter  int PC_W      = 16,
  localparam int MA_W      = $clog2(MEM_BYTES),
  localparam int DW_W      = MA_W - 3,
  localparam int PL_W      = (RIDX_W > DW_W) ? RIDX_W : DW_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic [PC_W-3:0]   imem_addr,
  input  logic [31:0]       imem_data,
  input  logic [PC_W-3:0]   prog_len,
  output logic [PC_W-1:0]   pc,
  output logic              halted,
  output logic              err,
  input  logic [RIDX_W-1:0] dbg_reg_sel,
  output logic [XLEN-1:0]   dbg_reg_val,
  input  logic [MA_W-1:0]   dbg_mem_addr,
  output logic [XLEN-1:0]   dbg_mem_dword,
  output logic [7:0]        dbg_mem_byte,
  input  logic              pl_reg_we,
  input  logic              pl_mem_we,
  input  logic [PL_W-1:0]   pl_idx,
  input  logic [XLEN-1:0]   pl_data
);
  logic [PC_W-1:0]   pc_q, pc_next, pc_tgt;
  logic              err_q, step, fault, commit, addr_bad, taken, rb_zero;
  ctrl_t             c;
  logic [XLEN-1:0]   imm, ra, rb, opb, alu, ld_data;
  logic [RIDX_W-1:0] rf_idx [3];
  logic [XLEN-1:0]   rf_val [3];
  logic              rf_we, dm_we;
  logic [RIDX_W-1:0] rf_widx;
  logic [XLEN-1:0]   rf_wdata, dm_wdata;
  logic [MA_W-1:0]   dm_addr;

  assign imem_addr = pc_q[PC_W-1:2];
  assign pc        = pc_q;
  assign err       = err_q;
  assign halted    = pc_q >= {prog_len, 2'b00};

  dwc_decode u_dec (.instr(imem_data), .ctrl(c), .imm(imm));

  assign rf_idx[0]   = c.rn;
  assign rf_idx[1]   = c.rb;
  assign rf_idx[2]   = dbg_reg_sel;
  assign ra          = rf_val[0];
  assign rb          = rf_val[1];
  assign dbg_reg_val = rf_val[2];

  // One adder serves arithmetic results and effective addresses
  assign opb = c.use_imm ? imm : rb;
  assign alu = c.do_sub ? ra - opb : ra + opb;

  assign addr_bad = (alu[2:0] != 3'b000) || (alu > XLEN'(MEM_BYTES - 8));
  assign step     = !rst && !err_q && !halted;
  assign fault    = step && (c.illegal || ((c.mem_rd || c.mem_wr) && addr_bad));
  assign commit   = step && !fault;

  assign rf_we    = rst ? pl_reg_we : (commit && c.wr_reg);
  assign rf_widx  = rst ? pl_idx[RIDX_W-1:0] : c.rd;
  assign rf_wdata = rst ? pl_data : (c.mem_rd ? ld_data : alu);

  assign dm_we    = rst ? pl_mem_we : (commit && c.mem_wr);
  assign dm_addr  = rst ? {pl_idx[DW_W-1:0], 3'b000} : alu[MA_W-1:0];
  assign dm_wdata = rst ? pl_data : rb;

  dwc_regfile #(.NRD(3)) u_rf (
    .clk(clk), .we(rf_we), .widx(rf_widx), .wdata(rf_wdata),
    .rd_idx(rf_idx), .rd_val(rf_val)
  );

  dwc_dmem #(.MEM_BYTES(MEM_BYTES)) u_dm (
    .clk(clk), .rst(rst), .we(dm_we), .addr(dm_addr), .wdata(dm_wdata),
    .rdata(ld_data), .dbg_addr(dbg_mem_addr), .dbg_dword(dbg_mem_dword),
    .dbg_byte(dbg_mem_byte)
  );

  // Next-PC: offsets count instructions, wrap to counter width
  assign rb_zero = (rb == '0);
  assign taken   = (c.pc_sel == PC_JUMP) || (c.pc_sel == PC_IFZ && rb_zero) ||
                   (c.pc_sel == PC_IFNZ && !rb_zero);
  assign pc_tgt  = pc_q + {imm[PC_W-3:0], 2'b00};
  assign pc_next = taken ? pc_tgt : pc_q + PC_W'(4);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      err_q <= 1'b0;
    end else begin
      if (fault)  err_q <= 1'b1;
      if (commit) pc_q  <= pc_next;
    end
  end

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
  p_fault_freeze_r6: assert property (@(posedge clk) disable iff (rst)
    err_q |=> $stable(pc_q));
  p_halt_hold_r10: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(pc_q));
  p_seq_advance_r3: assert property (@(posedge clk) disable iff (rst)
    (step && !c.illegal && c.pc_sel == PC_SEQ && !c.mem_rd && !c.mem_wr)
    |=> pc_q == $past(pc_q) + PC_W'(4));
endmodule

// File: tb/test_dwc_core.sv
module test_dwc_core;
  import dwc_pkg::*;
  localparam int PC_W = 16;
  localparam int MA_W = 8;
  localparam int PL_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [PC_W-3:0] imem_addr, prog_len;
  logic [31:0]     imem_data;
  logic [PC_W-1:0] pc;
  logic            halted, err;
  logic [4:0]      dbg_reg_sel;
  logic [63:0]     dbg_reg_val, dbg_mem_dword, pl_data;
  logic [MA_W-1:0] dbg_mem_addr;
  logic [7:0]      dbg_mem_byte;
  logic            pl_reg_we, pl_mem_we;
  logic [PL_W-1:0] pl_idx;
  logic [31:0]     rom [64];

  assign imem_data = (imem_addr < 14'd64) ? rom[imem_addr[5:0]] : 32'h0;

  dwc_core i_dwc_core (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .prog_len(prog_len), .pc(pc), .halted(halted), .err(err),
    .dbg_reg_sel(dbg_reg_sel), .dbg_reg_val(dbg_reg_val),
    .dbg_mem_addr(dbg_mem_addr), .dbg_mem_dword(dbg_mem_dword),
    .dbg_mem_byte(dbg_mem_byte), .pl_reg_we(pl_reg_we), .pl_mem_we(pl_mem_we),
    .pl_idx(pl_idx), .pl_data(pl_data)
  );

  int nchk = 0, nfail = 0, cyc = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(logic [5:0] op, int rd, int rn, int rm);
    return {op, 5'b0, 5'(rm), 6'b0, 5'(rn), 5'(rd)};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rd, int rn, int imm);
    return {op, 4'b0, 12'(imm), 5'(rn), 5'(rd)};
  endfunction
  function automatic logic [31:0] enc_d(logic [5:0] op, int rt, int rn, int off);
    return {op, 5'b0, 9'(off), 2'b0, 5'(rn), 5'(rt)};
  endfunction
  function automatic logic [31:0] enc_b(int off);
    return {OP_B, 26'(off)};
  endfunction
  function automatic logic [31:0] enc_cb(logic [5:0] op, int rt, int off);
    return {op, 2'b0, 19'(off), 5'(rt)};
  endfunction

  function automatic logic [63:0] tv(int k);
    case (k)
      0: return 64'h0;
      1: return 64'h1;
      2: return 64'h7FFF_FFFF_FFFF_FFFF;
      3: return 64'hFFFF_FFFF_FFFF_FFFF;
      4: return 64'h8000_0000_0000_0000;
      default: return 64'h0123_4567_89AB_CDEF;
    endcase
  endfunction

  task automatic rd_reg(input int i, output logic [63:0] v);
    dbg_reg_sel = 5'(i);
    #1 v = dbg_reg_val;
  endtask
  task automatic rd_mem(input int a, output logic [63:0] dw, output logic [7:0] by);
    dbg_mem_addr = 8'(a);
    #1;
    dw = dbg_mem_dword;
    by = dbg_mem_byte;
  endtask
  task automatic pl_reg(input int i, input logic [63:0] v);
    pl_reg_we = 1'b1; pl_idx = 5'(i); pl_data = v;
    @(negedge clk);
    pl_reg_we = 1'b0;
  endtask
  task automatic pl_mem(input int i, input logic [63:0] v);
    pl_mem_we = 1'b1; pl_idx = 5'(i); pl_data = v;
    @(negedge clk);
    pl_mem_we = 1'b0;
  endtask
  task automatic clear_rom();
    for (int i = 0; i < 64; i++) rom[i] = 32'h0;
  endtask
  task automatic reset_and_clear(input int len);
    rst = 1'b1;
    prog_len = 14'(len);
    @(negedge clk);
    for (int i = 0; i < 31; i++) pl_reg(i, 64'h0);
    for (int i = 0; i < 32; i++) pl_mem(i, 64'h0);
  endtask
  task automatic run(input int maxc);
    rst = 1'b0;
    for (int k = 0; k < maxc; k++) begin
      @(negedge clk);
      if (halted || err) break;
    end
  endtask
  task automatic check_reg(input string tag, input int i, input logic [63:0] exp);
    logic [63:0] v;
    rd_reg(i, v);
    check(tag, v, exp);
  endtask
  task automatic count_nonzero_mem(output int n);
    logic [63:0] dw;
    logic [7:0]  by;
    n = 0;
    for (int i = 0; i < 32; i++) begin
      rd_mem(8 * i, dw, by);
      if (dw != 64'h0) n++;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        nfail++;
        $display("FAIL watchdog actual=%0d expected=<190000 cycles", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
      end
    end
  end

  initial begin
    logic [63:0] v, dw;
    logic [7:0]  by;
    int          n;
    pl_reg_we = 0; pl_mem_we = 0; pl_idx = 0; pl_data = 0;
    dbg_reg_sel = 0; dbg_mem_addr = 0; prog_len = 0;
    clear_rom();

    // R1: reset state
    reset_and_clear(4);
    check("R1 pc", 64'(pc), 0);
    check("R1 err", 64'(err), 0);
    check("R1 halted", 64'(halted), 0);

    // R2: preload to register 31 discarded
    pl_reg(31, 64'h55);
    check_reg("R2 preload x31", 31, 0);

    // R3: register add/sub sweep, R2 zero register as source and destination
    for (int a = 0; a < 6; a++) begin
      for (int b = 0; b < 6; b++) begin
        clear_rom();
        rom[0] = enc_r(OP_ADD, 3, 1, 2);
        rom[1] = enc_r(OP_SUB, 4, 1, 2);
        rom[2] = enc_r(OP_ADD, 31, 1, 2);
        rom[3] = enc_r(OP_SUB, 5, 31, 2);
        reset_and_clear(4);
        pl_reg(1, tv(a));
        pl_reg(2, tv(b));
        run(20);
        check_reg("R3 add", 3, tv(a) + tv(b));
        check_reg("R3 sub", 4, tv(a) - tv(b));
        check_reg("R2 x31 write", 31, 0);
        check_reg("R2 x31 read", 5, 64'h0 - tv(b));
        check("R3 pc", 64'(pc), 16);
      end
    end

    // R4: immediate add/sub with zero extension
    for (int a = 0; a < 6; a++) begin
      for (int j = 0; j < 4; j++) begin
        int im;
        im = (j == 0) ? 0 : (j == 1) ? 1 : (j == 2) ? 2048 : 4095;
        clear_rom();
        rom[0] = enc_i(OP_ADDI, 3, 1, im);
        rom[1] = enc_i(OP_SUBI, 4, 1, im);
        reset_and_clear(2);
        pl_reg(1, tv(a));
        run(20);
        check_reg("R4 addi", 3, tv(a) + 64'(im));
        check_reg("R4 subi", 4, tv(a) - 64'(im));
      end
    end

    // R5: load/store addressing and big-endian layout
    for (int k = 0; k < 6; k++) begin
      int base, off, ad;
      logic [63:0] val;
      base = (k == 0) ? 16 : (k == 1) ? 256 : (k == 2) ? 0 : (k == 3) ? 100 : (k == 4) ? 200 : 255;
      off  = (k == 0) ? -8 : (k == 1) ? -256 : (k == 2) ? 248 : (k == 3) ? -4 : (k == 4) ? 48 : -255;
      ad   = base + off;
      val  = tv(5) ^ 64'(k * 32'h1111);
      clear_rom();
      rom[0] = enc_d(OP_STUR, 1, 2, off);
      rom[1] = enc_d(OP_LDUR, 6, 2, off);
      rom[2] = enc_d(OP_LDUR, 8, 9, -8);
      reset_and_clear(3);
      pl_reg(1, val);
      pl_reg(2, 64'(base));
      pl_reg(9, 64'd48);
      pl_mem(5, 64'hFEDC_BA98_7654_3210);
      run(20);
      check("R5 err", 64'(err), 0);
      check("R5 pc", 64'(pc), 12);
      check_reg("R5 load back", 6, val);
      check_reg("R5 load preloaded", 8, 64'hFEDC_BA98_7654_3210);
      rd_mem(ad, dw, by);
      check("R5 dword", dw, val);
      check("R5 msb byte", 64'(by), 64'(val[63:56]));
      rd_mem(ad + 7, dw, by);
      check("R5 lsb byte", 64'(by), 64'(val[7:0]));
      rd_mem(43, dw, by);
      check("R5 byte 43", 64'(by), 64'h98);
    end

    // R6/R11/R1: misaligned and out-of-range accesses
    for (int k = 0; k < 6; k++) begin
      for (int st = 0; st < 2; st++) begin
        int base, off;
        base = (k == 0) ? 3 : (k == 1) ? 0 : (k == 2) ? 256 : (k == 3) ? 250 : (k == 4) ? 240 : 7;
        off  = (k == 1) ? -8 : (k == 4) ? 16 : 0;
        clear_rom();
        rom[0] = enc_i(OP_ADDI, 20, 31, 7);
        rom[1] = (st == 1) ? enc_d(OP_STUR, 1, 2, off) : enc_d(OP_LDUR, 22, 2, off);
        rom[2] = enc_i(OP_ADDI, 21, 31, 9);
        reset_and_clear(3);
        pl_reg(1, tv(3));
        pl_reg(2, 64'(base));
        run(20);
        check("R6 err", 64'(err), 1);
        check("R6 pc frozen", 64'(pc), 4);
        check_reg("R6 prior commit", 20, 7);
        check_reg("R6 later skipped", 21, 0);
        check_reg("R6 load dest untouched", 22, 0);
        count_nonzero_mem(n);
        check("R6 memory untouched", 64'(n), 0);
        repeat (5) @(negedge clk);
        check("R11 err sticky", 64'(err), 1);
        check("R11 pc held", 64'(pc), 4);
      end
    end
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset clears err", 64'(err), 0);
    check("R1 reset clears pc", 64'(pc), 0);

    // R7: every unknown opcode
    for (int op = 0; op < 64; op++) begin
      if (op >= 1 && op <= 9) continue;
      clear_rom();
      rom[0] = enc_i(OP_ADDI, 1, 31, 5);
      rom[1] = {6'(op), 26'h000_0843};
      rom[2] = enc_i(OP_ADDI, 2, 31, 6);
      reset_and_clear(3);
      run(20);
      check("R7 err", 64'(err), 1);
      check("R7 pc", 64'(pc), 4);
      check_reg("R7 before", 1, 5);
      check_reg("R7 no write", 3, 0);
      check_reg("R7 after skipped", 2, 0);
    end

    // R8: unconditional jumps
    clear_rom();
    rom[0] = enc_b(2);
    rom[1] = enc_i(OP_ADDI, 1, 31, 1);
    rom[2] = enc_i(OP_ADDI, 2, 31, 2);
    reset_and_clear(3);
    run(20);
    check_reg("R8 skipped", 1, 0);
    check_reg("R8 target", 2, 2);
    check("R8 pc", 64'(pc), 12);

    clear_rom();
    rom[0] = enc_i(OP_ADDI, 1, 31, 1);
    rom[1] = enc_b(-2);
    reset_and_clear(2);
    run(20);
    check("R8 backward wrap pc", 64'(pc), 64'hFFFC);
    check("R10 halted after wrap", 64'(halted), 1);

    clear_rom();
    rom[0] = enc_b(33554431);
    reset_and_clear(1);
    run(20);
    check("R8 max imm26 pc", 64'(pc), 64'hFFFC);

    clear_rom();
    rom[0] = enc_b(0);
    reset_and_clear(1);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    check("R8 self jump pc", 64'(pc), 0);
    check("R8 self jump running", 64'(halted), 0);

    // R9: conditional jumps over several register values
    for (int s = 0; s < 5; s++) begin
      for (int nz = 0; nz < 2; nz++) begin
        logic tk;
        tk = (nz == 0) ? (tv(s) == 0) : (tv(s) != 0);
        clear_rom();
        rom[0] = enc_cb((nz == 1) ? OP_CBNZ : OP_CBZ, 1, 2);
        rom[1] = enc_i(OP_ADDI, 2, 31, 1);
        rom[2] = enc_i(OP_ADDI, 3, 31, 1);
        reset_and_clear(3);
        pl_reg(1, tv(s));
        run(20);
        check_reg("R9 fallthrough", 2, tk ? 64'h0 : 64'h1);
        check_reg("R9 target", 3, 1);
        check("R9 pc", 64'(pc), 12);
      end
    end

    // R9/R5: loop summing an array with a backward conditional jump
    clear_rom();
    rom[0] = enc_r(OP_ADD, 4, 31, 31);
    rom[1] = enc_d(OP_LDUR, 5, 1, 0);
    rom[2] = enc_r(OP_ADD, 4, 4, 5);
    rom[3] = enc_i(OP_ADDI, 1, 1, 8);
    rom[4] = enc_i(OP_SUBI, 2, 2, 1);
    rom[5] = enc_cb(OP_CBNZ, 2, -4);
    rom[6] = enc_d(OP_STUR, 4, 3, 8);
    reset_and_clear(7);
    for (int i = 0; i < 5; i++) pl_mem(2 + i, 64'(i + 1));
    pl_reg(1, 16);
    pl_reg(2, 5);
    pl_reg(3, 48);
    run(200);
    check_reg("R9 loop sum", 4, 15);
    check_reg("R9 loop pointer", 1, 56);
    check_reg("R9 loop count", 2, 0);
    check_reg("R9 loop last", 5, 5);
    rd_mem(56, dw, by);
    check("R5 loop store", dw, 15);

    // R10: hold after halt, and zero-length program
    repeat (5) @(negedge clk);
    check("R10 pc held", 64'(pc), 28);
    check_reg("R10 regs held", 4, 15);
    clear_rom();
    rom[0] = enc_i(OP_ADDI, 1, 31, 3);
    reset_and_clear(0);
    check("R10 empty halted in reset", 64'(halted), 1);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check("R10 empty pc", 64'(pc), 0);
    check_reg("R10 empty no exec", 1, 0);

    // R12: preload port ignored outside reset
    pl_reg(7, 64'hDEAD_BEEF);
    pl_mem(3, 64'hCAFE_F00D);
    check_reg("R12 reg preload ignored", 7, 0);
    rd_mem(24, dw, by);
    check("R12 mem preload ignored", dw, 0);
    rst = 1'b1;
    @(negedge clk);
    pl_reg(7, 64'h1234);
    check_reg("R12 reg preload in reset", 7, 64'h1234);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule